// File: doc/BRIEF.md
# Accelerometer FIFO Drain Sequencer

This block is an SPI master that empties the sample FIFO of a three-axis accelerometer after a single start strobe. It runs two short register reads, each in its own chip-select frame. The first read returns the interrupt-source byte, the second the FIFO-status byte. The low six bits of the status byte give the number of queued samples. The block then runs one seven-byte burst per queued sample. Each burst uses the device's address auto-increment to read the six axis data registers in one frame.

The device moves to its next queued sample only after chip select has stayed high for a minimum time. For this reason, every frame is followed by a chip-select-high gap of a programmed number of clock cycles. Each burst yields one 48-bit XYZ word, which is marked by a one-cycle valid strobe. The captured interrupt-source byte and entry count stay on outputs until the next drain. A host pulses `start`, consumes the sample stream, and waits for `done`.

Top module: `accel_fifo_drain`

## Requirements
- R1: After reset, cs_n and sclk are 1, and busy, done and sample_valid are 0.
- R2: A start pulse while idle begins a drain. Its first frame is two bytes long and carries command 0xB0 (bit 7 = 1 read, bit 6 = 0 single, bits 5:0 = 0x30). The second byte received is presented on int_src.
- R3: The second frame is two bytes long with command 0xB9 (read, single, address 0x39). Bits 5:0 of the byte received are presented on entry_count.
- R4: Between any two consecutive frames of a drain, cs_n stays high for at least GAP_CYCLES clock cycles.
- R5: One seven-byte frame follows per counted entry, each with command 0xF2 (read, bit 6 = 1 multi-byte, address 0x32). A count of zero produces no such frame.
- R6: After the sixth data byte of an entry frame, sample_valid is high for exactly one cycle. The sample is {Z1,Z0,Y1,Y0,X1,X0}: data byte k (k = 1..6) occupies bits 8k-1 down to 8k-8.
- R7: SPI mode 3. sclk is high whenever cs_n is high. mosi changes only while sclk is low. Both directions are MSB first, and miso is sampled on the rising edge. Every frame holds a whole number of bytes.
- R8: busy is high from the cycle after start until the drain ends. The drain ends with a one-cycle done pulse, issued after the final gap, with busy low.
- R9: A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a drain (honoured when idle) |
| miso | input | 1 | Serial data from device |
| sclk | output | 1 | SPI clock, idles high |
| mosi | output | 1 | Serial data to device |
| cs_n | output | 1 | Active-low chip select |
| busy | output | 1 | Drain in progress |
| done | output | 1 | One-cycle end-of-drain pulse |
| int_src | output | 8 | Captured interrupt-source byte |
| entry_count | output | 6 | Captured number of queued samples |
| sample | output | 48 | Assembled XYZ sample |
| sample_valid | output | 1 | One-cycle strobe for sample |

## Verification
The hardest condition to reach is a long drain of back-to-back bursts. It needs a device that returns a different payload for every queued sample and advances only on chip-select release. Without that, misordered bytes or a missing gap would not show. The bench contains a behavioural mode-3 device with a register file and a queue pointer. The pointer advances on each chip-select rise that ends a data burst. The bench runs drains of 0, 1, 3, 5 and 32 entries, with status bytes whose upper bits are set, and checks every sample against the queue contents. A second start pulse is injected in the middle of a burst.

// File: rtl/accel_fifo_drain.sv
module accel_fifo_drain #(
  parameter int CLK_DIV    = 20,
  parameter int GAP_CYCLES = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        miso,
  output logic        sclk,
  output logic        mosi,
  output logic        cs_n,
  output logic        busy,
  output logic        done,
  output logic [7:0]  int_src,
  output logic [5:0]  entry_count,
  output logic [47:0] sample,
  output logic        sample_valid
);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int GAP_W = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES) : 1;
  localparam logic [7:0] CMD_INT  = 8'hB0;
  localparam logic [7:0] CMD_STAT = 8'hB9;
  localparam logic [7:0] CMD_DATA = 8'hF2;

  typedef enum logic [1:0] {S_IDLE, S_LEAD, S_XFER, S_GAP} st_t;
  typedef enum logic [1:0] {F_INT, F_STAT, F_DATA} fr_t;

  st_t              st;
  fr_t              fr;
  logic [DIV_W-1:0] div_q;
  logic [GAP_W-1:0] gap_q;
  logic             ph;
  logic [2:0]       bit_q, byte_q;
  logic [7:0]       tx_q, rx_q;
  logic [5:0]       left_q;
  logic             valid_q, done_q;

  wire div_end   = (div_q == DIV_W'(CLK_DIV - 1));
  wire gap_end   = (gap_q == GAP_W'(GAP_CYCLES - 1));
  wire last_byte = (fr == F_DATA) ? (byte_q == 3'd6) : (byte_q == 3'd1);

  assign cs_n         = (st == S_IDLE) || (st == S_GAP);
  assign sclk         = !((st == S_XFER) && !ph);
  assign mosi         = tx_q[7];
  assign busy         = (st != S_IDLE);
  assign done         = done_q;
  assign sample_valid = valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      fr          <= F_INT;
      div_q       <= '0;
      gap_q       <= '0;
      ph          <= 1'b0;
      bit_q       <= '0;
      byte_q      <= '0;
      tx_q        <= CMD_INT;
      rx_q        <= '0;
      left_q      <= '0;
      int_src     <= '0;
      entry_count <= '0;
      sample      <= '0;
      valid_q     <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st     <= S_LEAD;
          fr     <= F_INT;
          tx_q   <= CMD_INT;
          div_q  <= '0;
          ph     <= 1'b0;
          bit_q  <= '0;
          byte_q <= '0;
        end
        S_LEAD: begin
          if (div_end) begin
            div_q <= '0;
            ph    <= 1'b0;
            st    <= S_XFER;
          end else begin
            div_q <= div_q + DIV_W'(1);
          end
        end
        S_XFER: begin
          if (!div_end) begin
            div_q <= div_q + DIV_W'(1);
          end else begin
            div_q <= '0;
            ph    <= ~ph;
            if (!ph) begin
              rx_q <= {rx_q[6:0], miso};
            end else begin
              tx_q  <= {tx_q[6:0], 1'b0};
              bit_q <= bit_q + 3'd1;
              if (bit_q == 3'd7) begin
                byte_q <= byte_q + 3'd1;
                tx_q   <= 8'h00;
                case (fr)
                  F_INT:  if (byte_q == 3'd1) int_src <= rx_q;
                  F_STAT: if (byte_q == 3'd1) begin
                    entry_count <= rx_q[5:0];
                    left_q      <= rx_q[5:0];
                  end
                  default: if (byte_q != 3'd0) begin
                    sample[{byte_q - 3'd1, 3'b000} +: 8] <= rx_q;
                    if (byte_q == 3'd6) begin
                      valid_q <= 1'b1;
                      left_q  <= left_q - 6'd1;
                    end
                  end
                endcase
                if (last_byte) begin
                  st    <= S_GAP;
                  gap_q <= '0;
                end
              end
            end
          end
        end
        default: begin
          if (!gap_end) begin
            gap_q <= gap_q + GAP_W'(1);
          end else begin
            div_q  <= '0;
            ph     <= 1'b0;
            bit_q  <= '0;
            byte_q <= '0;
            if (fr == F_INT) begin
              fr   <= F_STAT;
              tx_q <= CMD_STAT;
              st   <= S_LEAD;
            end else if (left_q == 6'd0) begin
              st     <= S_IDLE;
              done_q <= 1'b1;
            end else begin
              fr   <= F_DATA;
              tx_q <= CMD_DATA;
              st   <= S_LEAD;
            end
          end
        end
      endcase
    end
  end
endmodule

module accel_fifo_drain_chk #(
  parameter int GAP_CYCLES = 1000
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sclk,
  input logic mosi,
  input logic busy,
  input logic done,
  input logic sample_valid
);
  localparam int HW = $clog2(GAP_CYCLES + 1) + 1;
  logic [HW-1:0] hi_cnt;
  logic          had;
  logic          sclk_q;
  logic [2:0]    edge_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt   <= '0;
      had      <= 1'b0;
      sclk_q   <= 1'b1;
      edge_cnt <= '0;
    end else begin
      sclk_q <= sclk;
      if (!cs_n) hi_cnt <= '0;
      else if (hi_cnt < HW'(GAP_CYCLES)) hi_cnt <= hi_cnt + HW'(1);
      if (!busy) had <= 1'b0;
      else if (!cs_n) had <= 1'b1;
      if (cs_n) edge_cnt <= '0;
      else if (sclk && !sclk_q) edge_cnt <= edge_cnt + 3'd1;
    end
  end

  AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk); // R7
  AST_MOSI_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !$past(cs_n) && sclk && $past(sclk)) |-> $stable(mosi)); // R7
  AST_WHOLE_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (edge_cnt == 3'd0)); // R7
  AST_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cs_n) && had) |-> (hi_cnt >= HW'(GAP_CYCLES))); // R4
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> !sample_valid); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R8
  AST_CS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n); // R8
endmodule

bind accel_fifo_drain accel_fifo_drain_chk #(.GAP_CYCLES(GAP_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
  .busy(busy), .done(done), .sample_valid(sample_valid)
);

// File: tb/tb_accel_fifo_drain.sv
`timescale 1ns/1ps
module tb_accel_fifo_drain;
  localparam int DIV = 2;
  localparam int GAP = 16;
  localparam int NV  = 5;
  // {interrupt byte, status byte, expected count}
  localparam logic [23:0] VEC [NV] = '{24'h83_03_03, 24'h02_00_00, 24'hFF_C5_05,
                                       24'h00_01_01, 24'h5A_E0_20};

  logic clk = 1'b0, rst_n, start = 1'b0, miso = 1'b0;
  logic sclk, mosi, cs_n, busy, done, sample_valid;
  logic [7:0] int_src;
  logic [5:0] entry_count;
  logic [47:0] sample;

  always #2.5 clk = ~clk;

  accel_fifo_drain #(.CLK_DIV(DIV), .GAP_CYCLES(GAP)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .miso(miso), .sclk(sclk),
    .mosi(mosi), .cs_n(cs_n), .busy(busy), .done(done), .int_src(int_src),
    .entry_count(entry_count), .sample(sample), .sample_valid(sample_valid));

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural device
  logic [7:0] int_val, stat_val;
  int run_id, pop_idx;
  logic [7:0] m_in, m_cmd, out_sh;
  logic [5:0] m_ptr;
  int m_bits;
  bit logging = 0;
  logic [7:0] f_cmd [0:39];
  int f_bits [0:39];
  int nframes, s_idx, done_cnt, hi_run;
  logic cs_prev;
  bit samp_ok;

  function automatic logic [7:0] dbyte(input int r, input int e, input int k);
    return 8'(r * 37 + e * 13 + k * 5 + 1);
  endfunction

  function automatic logic [7:0] reg_rd(input logic [5:0] a);
    if (a == 6'h30) return int_val;
    if (a == 6'h39) return stat_val;
    if (a >= 6'h32 && a <= 6'h37) return dbyte(run_id, pop_idx, int'(a) - 'h32);
    return 8'hEE;
  endfunction

  always @(negedge cs_n) m_bits = 0;

  always @(posedge sclk) if (cs_n === 1'b0) begin
    m_in = {m_in[6:0], mosi};
    m_bits++;
    if (m_bits % 8 == 0) begin
      if (m_bits == 8) begin
        m_cmd = m_in;
        m_ptr = m_in[5:0];
      end else if (m_cmd[6]) begin
        m_ptr = m_ptr + 6'd1;
      end
      out_sh = reg_rd(m_ptr);
    end
  end

  always @(negedge sclk) if (cs_n === 1'b0) begin
    miso = out_sh[7];
    out_sh = {out_sh[6:0], 1'b0};
  end

  always @(posedge cs_n) if (logging) begin
    if (nframes < 40) begin
      f_cmd[nframes] = m_cmd;
      f_bits[nframes] = m_bits;
    end
    if (m_cmd[5:0] == 6'h32 && m_bits >= 56) pop_idx++;
    nframes++;
  end

  always @(negedge clk) if (logging) begin
    if (sample_valid) begin
      logic [47:0] e;
      for (int k = 0; k < 6; k++) e[8*k +: 8] = dbyte(run_id, s_idx, k);
      if (sample !== e) begin
        samp_ok = 0;
        chk(0, "R6 sample", {16'h0, sample}, {16'h0, e});
      end
      s_idx++;
    end
    if (done) done_cnt++;
    if (cs_n) hi_run++;
    else begin
      if (cs_prev && nframes > 0) chk(hi_run >= GAP, "R4 cs gap", 64'(hi_run), 64'(GAP));
      hi_run = 0;
    end
    cs_prev = cs_n;
  end

  task automatic run(input int idx, input logic [23:0] v, input bit poke);
    int t;
    bit cmd_ok;
    int exp_n;
    int_val = v[23:16];
    stat_val = v[15:8];
    exp_n = int'(v[7:0]);
    run_id = idx;
    pop_idx = 0; nframes = 0; s_idx = 0; done_cnt = 0; hi_run = 0;
    cs_prev = 1'b1; samp_ok = 1;
    logging = 1;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(busy === 1'b1, "R8 busy after start", 64'(busy), 64'd1);
    if (poke) begin
      repeat (300) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    t = 0;
    while (done_cnt == 0 && t < 60000) begin
      @(negedge clk);
      t++;
    end
    repeat (5) @(negedge clk);
    logging = 0;
    chk(busy === 1'b0, "R8 idle at end", 64'(busy), 64'd0);
    chk(done_cnt == 1, "R8 single done", 64'(done_cnt), 64'd1);
    chk(int_src === int_val, "R2 int_src", 64'(int_src), 64'(int_val));
    chk(f_cmd[0] === 8'hB0 && f_bits[0] == 16, "R2 first frame",
        {f_cmd[0], 32'(f_bits[0])}, {8'hB0, 32'd16});
    chk(entry_count === v[13:8], "R3 entry_count", 64'(entry_count), 64'(v[13:8]));
    chk(f_cmd[1] === 8'hB9 && f_bits[1] == 16, "R3 second frame",
        {f_cmd[1], 32'(f_bits[1])}, {8'hB9, 32'd16});
    chk(nframes == 2 + exp_n, poke ? "R9 start while busy ignored" : "R5 frame count",
        64'(nframes), 64'(2 + exp_n));
    cmd_ok = 1;
    for (int k = 2; k < nframes && k < 40; k++)
      if (f_cmd[k] !== 8'hF2 || f_bits[k] != 56) cmd_ok = 0;
    chk(cmd_ok, "R5 burst frames 0xF2 x7 bytes, R7 whole bytes", 64'(cmd_ok), 64'd1);
    chk(s_idx == exp_n && samp_ok, "R6 sample stream", 64'(s_idx), 64'(exp_n));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      chk(0, "watchdog", 64'd0, 64'd1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(cs_n === 1'b1 && sclk === 1'b1, "R1 reset pins", {62'd0, cs_n, sclk}, 64'd3);
    chk(busy === 1'b0 && done === 1'b0 && sample_valid === 1'b0, "R1 reset flags",
        {61'd0, busy, done, sample_valid}, 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(cs_n === 1'b1 && busy === 1'b0, "R1 idle after reset", {62'd0, cs_n, busy}, 64'd2);
    for (int i = 0; i < NV; i++) begin
      run(i, VEC[i], 1'b0);
      repeat (10) @(negedge clk);
    end
    run(NV, 24'h11_03_03, 1'b1);
    chk(sclk === 1'b1 && cs_n === 1'b1, "R7 idle clock high", {62'd0, sclk, cs_n}, 64'd3);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule